// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit handles flow control for one UART channel. It sits on two paths. On the receive path it lies between the character deserializer and the receive FIFO. There it looks for programmed software flow control codes, either one byte or a pair of consecutive bytes. Matched codes are taken out of the data stream, and they pause or resume the local transmitter. On the transmit path it decides whether the shifter may start its next character. That start needs no pending software pause and, when hardware gating is enabled, an asserted CTS input.

The unit also drives the active-low RTS pin. In hardware flow control, RTS is withdrawn when the receive FIFO fill reaches the trigger level. It is given back only once the fill has drained below that level by a hysteresis margin. When half-duplex bus direction control is enabled, it owns the pin: RTS is asserted while the transmitter is active, whatever the FIFO fill. The RTS side and the CTS side are enabled independently. Neither one depends on any interrupt setting.

Received bytes are assumed to arrive at least three clock cycles apart. The configuration mode changes only while no first byte of a pair is held.

Top module: `uart_autoflow`

## Requirements
- R1: With `sw_mode` 00 or 11 (off), each received byte is written to the FIFO unchanged on the cycle after `rx_valid`, and the software pause is cleared.
- R2: With `sw_mode` 01 (single), a byte equal to `xoff1` sets the pause and a byte equal to `xon1` clears it. When both codes are equal, the pause takes priority. A matched byte is not written to the FIFO.
- R3: With `sw_mode` 10 (pair), the sequence `xoff1`,`xoff2` sets the pause and the sequence `xon1`,`xon2` clears it. The pause pair is tested first. Neither byte of a matched pair is written.
- R4: In pair mode, when a held first byte is followed by a byte that does not complete its pair, both are written as data in arrival order. The held byte is written on the cycle after the second byte arrives, and the second byte on the cycle after that.
- R5: Once paused, `tx_go` stays low until a matching resume code arrives or software flow control is switched off.
- R6: With `auto_cts_en` high, `tx_go` = `tx_req` and not paused and CTS asserted, where `cts_n` passes through a two-flop synchronizer. A change of `cts_n` reaches `tx_go` after two clock edges.
- R7: With `auto_rts_en` high and `rs485_en` low, `rts_n` goes high one cycle after `rx_level` >= `rx_trig`. It returns low only once `rx_level` + 1 < `rx_trig`, so `rts_n` holds high at `rx_trig`-1.
- R8: With `auto_rts_en` and `rs485_en` both low, `rts_n` is low whatever the FIFO fill.
- R9: With `rs485_en` high, `rts_n` is the inverse of `tx_active`, regardless of `rx_level` or `auto_rts_en`.
- R10: With `auto_cts_en` low, `cts_n` has no effect on `tx_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode | input | 2 | Software flow control mode: 00 off, 01 single, 10 pair |
| xon1 | input | 8 | Resume code, first byte |
| xon2 | input | 8 | Resume code, second byte |
| xoff1 | input | 8 | Pause code, first byte |
| xoff2 | input | 8 | Pause code, second byte |
| auto_rts_en | input | 1 | Enable RTS from FIFO fill |
| auto_cts_en | input | 1 | Enable CTS gating of the transmitter |
| rs485_en | input | 1 | Bus direction control owns RTS |
| rx_trig | input | 5 | Receive trigger level |
| rx_level | input | 5 | Current receive FIFO fill |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Receive FIFO write data |
| tx_req | input | 1 | Shifter requests the next character |
| tx_go | output | 1 | Shifter may start the next character |
| tx_active | input | 1 | Transmitter holds or shifts data |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The hardest case to reach from the ports is a broken pair in pair mode. A byte equal to a first code has to be followed by a byte that matches no second code. The unit must then emit two writes on consecutive cycles, and the pause state must not change. Uniform random bytes almost never line up this way. The stimulus therefore draws most of its bytes from the four programmed codes plus a few other values. This produces broken pairs, crossed pairs (pause start, resume end), and repeated first bytes often. A reference model in the bench tracks the held byte and the pause state, and the FIFO writes and `tx_go` are compared with it.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;
  typedef enum logic [1:0] {
    SWFC_OFF = 2'b00,
    SWFC_ONE = 2'b01,
    SWFC_TWO = 2'b10
  } swfc_mode_e;

  // true when the fill has drained far enough below the trigger
  function automatic logic rts_may_release(int level, int trig, int hyst);
    return (level + hyst) < trig;
  endfunction

  function automatic logic is_code(logic [7:0] b, logic [7:0] code);
    return b == code;
  endfunction
endpackage

// File: rtl/afc_sw_filter.sv
module afc_sw_filter
  import uart_afc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sw_mode,
  input  logic [7:0] xon1,
  input  logic [7:0] xon2,
  input  logic [7:0] xoff1,
  input  logic [7:0] xoff2,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       fifo_wr,
  output logic [7:0] fifo_wdata,
  output logic       paused
);
  logic       held_q, held_on_q, held_off_q;
  logic [7:0] held_byte_q;
  logic       pend_q;
  logic [7:0] pend_byte_q;

  logic mode_one, mode_two, mode_off;
  assign mode_one = (sw_mode == SWFC_ONE);
  assign mode_two = (sw_mode == SWFC_TWO);
  assign mode_off = !mode_one && !mode_two;

  // named events for the checks
  logic hit_off, hit_on, start_pair, partial_miss, pass_byte;
  always_comb begin
    hit_off      = 1'b0;
    hit_on       = 1'b0;
    start_pair   = 1'b0;
    partial_miss = 1'b0;
    pass_byte    = 1'b0;
    if (rx_valid) begin
      if (mode_one) begin
        if (is_code(rx_data, xoff1))     hit_off = 1'b1;
        else if (is_code(rx_data, xon1)) hit_on  = 1'b1;
        else                             pass_byte = 1'b1;
      end else if (mode_two) begin
        if (held_q) begin
          if (held_off_q && is_code(rx_data, xoff2))     hit_off = 1'b1;
          else if (held_on_q && is_code(rx_data, xon2))  hit_on  = 1'b1;
          else                                           partial_miss = 1'b1;
        end else if (is_code(rx_data, xoff1) || is_code(rx_data, xon1)) begin
          start_pair = 1'b1;
        end else begin
          pass_byte = 1'b1;
        end
      end else begin
        pass_byte = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr     <= 1'b0;
      fifo_wdata  <= '0;
      paused      <= 1'b0;
      held_q      <= 1'b0;
      held_on_q   <= 1'b0;
      held_off_q  <= 1'b0;
      held_byte_q <= '0;
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else begin
      fifo_wr <= 1'b0;
      if (pend_q) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= pend_byte_q;
        pend_q     <= 1'b0;
      end
      if (pass_byte) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= rx_data;
      end
      if (start_pair) begin
        held_q      <= 1'b1;
        held_byte_q <= rx_data;
        held_on_q   <= is_code(rx_data, xon1);
        held_off_q  <= is_code(rx_data, xoff1);
      end
      if (hit_off || hit_on || partial_miss) held_q <= 1'b0;
      if (partial_miss) begin
        fifo_wr     <= 1'b1;
        fifo_wdata  <= held_byte_q;
        pend_q      <= 1'b1;
        pend_byte_q <= rx_data;
      end
      if (hit_off)      paused <= 1'b1;
      else if (hit_on)  paused <= 1'b0;
      if (mode_off)     paused <= 1'b0;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_off) |=> (fifo_wr && fifo_wdata == $past(rx_data))); // R1
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> !paused); // R1
  AST_CODE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_off || hit_on || start_pair) |=> !fifo_wr); // R2
  AST_PAIR_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_off && mode_two) |=> paused); // R3
  AST_PARTIAL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    partial_miss |=> fifo_wr ##1 fifo_wr); // R4
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !hit_on && !mode_off) |=> paused); // R5
endmodule

// File: rtl/afc_rts_ctl.sv
module afc_rts_ctl
  import uart_afc_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int HYST  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             rs485_en,
  input  logic             tx_active,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_n
);
  logic rts_hold_q;
  logic fill_hit, fill_release;
  assign fill_hit     = (rx_level >= rx_trig);
  assign fill_release = rts_may_release(int'(rx_level), int'(rx_trig), HYST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rts_hold_q <= 1'b0;
    else if (!auto_rts_en)  rts_hold_q <= 1'b0;
    else if (fill_hit)      rts_hold_q <= 1'b1;
    else if (fill_release)  rts_hold_q <= 1'b0;
  end

  assign rts_n = rs485_en ? !tx_active : rts_hold_q;

  AST_RTS_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(auto_rts_en && fill_hit) && auto_rts_en && !rs485_en) |-> rts_n); // R7
  AST_RTS_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!auto_rts_en) && !rs485_en) |-> !rts_n); // R8
  AST_RS485_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs485_en && tx_active) |-> !rts_n); // R9
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic cts_n,
  input  logic paused,
  input  logic tx_req,
  output logic tx_go
);
  logic [1:0] cts_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync_q <= 2'b11;
    else        cts_sync_q <= {cts_sync_q[0], cts_n};
  end

  logic cts_ok;
  assign cts_ok = !auto_cts_en || !cts_sync_q[1];
  assign tx_go  = tx_req && !paused && cts_ok;

  AST_NO_START_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !tx_go); // R5
  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && auto_cts_en && $past(cts_n) && $past(cts_n, 2)) |-> !tx_go); // R6
  AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts_en && tx_req && !paused) |-> tx_go); // R10
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_afc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HYST  = 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sw_mode,
  input  logic [7:0]       xon1,
  input  logic [7:0]       xon2,
  input  logic [7:0]       xoff1,
  input  logic [7:0]       xoff2,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             rs485_en,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             fifo_wr,
  output logic [7:0]       fifo_wdata,
  input  logic             tx_req,
  output logic             tx_go,
  input  logic             tx_active,
  input  logic             cts_n,
  output logic             rts_n
);
  logic sw_paused;

  afc_sw_filter u_filt (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .paused(sw_paused)
  );

  afc_rts_ctl #(.LVL_W(LVL_W), .HYST(HYST)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .rs485_en(rs485_en),
    .tx_active(tx_active), .rx_trig(rx_trig), .rx_level(rx_level), .rts_n(rts_n)
  );

  afc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .cts_n(cts_n),
    .paused(sw_paused), .tx_req(tx_req), .tx_go(tx_go)
  );
endmodule

// File: tb/sim_uart_autoflow.sv
module sim_uart_autoflow;
  logic       clk = 0, rst_n = 0;
  logic [1:0] sw_mode = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h21, xoff1 = 8'h13, xoff2 = 8'h23;
  logic       auto_rts_en = 0, auto_cts_en = 0, rs485_en = 0;
  logic [4:0] rx_trig = 5'd8, rx_level = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic       fifo_wr;
  logic [7:0] fifo_wdata;
  logic       tx_req = 1, tx_go, tx_active = 0, cts_n = 1, rts_n;

  always #2 clk = ~clk;

  uart_autoflow u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] cap [0:4095];
  int cap_n = 0;
  logic [7:0] exp_q [0:4095];
  int exp_n = 0;
  bit m_paused = 0, m_held = 0, m_hon = 0, m_hoff = 0;
  logic [7:0] m_hbyte = 0;

  always @(negedge clk) if (fifo_wr && cap_n < 4096) begin cap[cap_n] = fifo_wdata; cap_n++; end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic bit m_off(logic [1:0] m); return !(m == 2'b01 || m == 2'b10); endfunction

  task automatic ref_byte(logic [7:0] b);
    if (sw_mode == 2'b01) begin
      if (b == xoff1) m_paused = 1; else if (b == xon1) m_paused = 0;
      else begin exp_q[exp_n] = b; exp_n++; end
    end else if (sw_mode == 2'b10) begin
      if (m_held) begin
        m_held = 0;
        if (m_hoff && b == xoff2) m_paused = 1;
        else if (m_hon && b == xon2) m_paused = 0;
        else begin exp_q[exp_n] = m_hbyte; exp_q[exp_n+1] = b; exp_n += 2; end
      end else if (b == xoff1 || b == xon1) begin
        m_held = 1; m_hbyte = b; m_hon = (b == xon1); m_hoff = (b == xoff1);
      end else begin exp_q[exp_n] = b; exp_n++; end
    end else begin
      m_paused = 0; exp_q[exp_n] = b; exp_n++;
    end
  endtask

  task automatic send(logic [7:0] b, string req);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk);
    ref_byte(b);
    check({req, " write count"}, cap_n, exp_n);
    if (cap_n == exp_n && exp_n > 0) check({req, " last byte"}, cap[cap_n-1], exp_q[exp_n-1]);
    if (m_off(sw_mode)) m_paused = 0;
    check({req, " tx_go vs pause"}, tx_go, !m_paused);
  endtask

  task automatic set_mode(logic [1:0] m);
    if (m_held) send(8'h00, "R4 flush");
    @(negedge clk); sw_mode = m;
    @(negedge clk); if (m_off(m)) m_paused = 0;
  endtask

  function automatic logic [7:0] pick();
    int r = $urandom_range(0, 5);
    case (r)
      0: return xon1; 1: return xon2; 2: return xoff1; 3: return xoff2;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset rts_n", rts_n, 0);
    check("R1 reset fifo_wr", fifo_wr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R10 reset tx_go", tx_go, 1);

    // R1 pass-through
    sw_mode = 2'b00;
    send(8'h13, "R1 off code");
    for (int i = 0; i < 20; i++) send(8'($urandom_range(0, 255)), "R1 random");

    // R2 single-code mode
    set_mode(2'b01);
    send(8'h13, "R2 xoff");
    check("R5 paused go low", tx_go, 0);
    send(8'h42, "R5 data while paused");
    send(8'h11, "R2 xon");
    for (int i = 0; i < 200; i++) send(pick(), "R2 random");
    send(8'h13, "R5 pause before off");
    set_mode(2'b00);
    check("R1 off clears pause", tx_go, 1);

    // R3/R4 pair mode
    set_mode(2'b10);
    send(8'h13, "R3 xoff first");
    send(8'h23, "R3 xoff second");
    check("R3 paused", tx_go, 0);
    send(8'h11, "R4 xon first");
    send(8'h23, "R4 crossed pair");
    check("R4 first flushed", cap[cap_n-2], 8'h11);
    send(8'h11, "R3 xon first");
    send(8'h21, "R3 xon second");
    for (int i = 0; i < 600; i++) send(pick(), "R3 random");
    set_mode(2'b00);

    // R6/R10 CTS
    auto_cts_en = 0; cts_n = 1;
    repeat (3) @(negedge clk);
    check("R10 cts ignored", tx_go, 1);
    auto_cts_en = 1;
    @(negedge clk);
    check("R6 cts high blocks", tx_go, 0);
    cts_n = 0;
    @(negedge clk);
    check("R6 one edge not yet", tx_go, 0);
    @(negedge clk);
    check("R6 after two edges", tx_go, 1);
    tx_req = 0; @(negedge clk);
    check("R6 no request", tx_go, 0);
    tx_req = 1; auto_cts_en = 0;

    // R7/R8/R9 RTS
    rx_level = 5'd12; @(negedge clk);
    check("R8 auto off rts low", rts_n, 0);
    auto_rts_en = 1; rx_level = 5'd7; @(negedge clk);
    check("R7 below trig", rts_n, 0);
    rx_level = 5'd8; @(negedge clk);
    check("R7 at trig", rts_n, 1);
    rx_level = 5'd7; @(negedge clk);
    check("R7 hysteresis hold", rts_n, 1);
    rx_level = 5'd6; @(negedge clk);
    check("R7 release", rts_n, 0);
    rx_level = 5'd15; rs485_en = 1; tx_active = 1; @(negedge clk);
    check("R9 active", rts_n, 0);
    tx_active = 0; @(negedge clk);
    check("R9 idle", rts_n, 1);
    rs485_en = 0; @(negedge clk);
    check("R7 full again", rts_n, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule